// File: doc/BRIEF.md
# Folded-Reference Three-Level PWM Modulator

This block produces the gating information for a three-level current-source inverter built from two bridges in parallel. It uses a single triangular carrier and no stacked carriers. Each carrier period it takes one signed reference sample and a peak amplitude setting. From these it forms the magnitude of the reference, measured in carrier counts.

The magnitude feeds a fold stage. Below half the carrier peak the magnitude is doubled. Above that point the excess is mirrored downward, so the folded value returns toward zero as the magnitude nears the peak. The folded value is compared against the carrier to give the pulse train. A level-select flag tells a downstream switch decoder whether the pulses move the output between zero and the first level, or between the first and second levels. A polarity flag gives the half-cycle. A strobe marks each carrier valley.

The modulation index is the amplitude setting divided by the carrier peak. All sampled quantities change only at a valley, so the comparator never sees a reference step in the middle of a period.

Top module: `folded_ref_pwm`

## Requirements
- R1: After reset the carrier starts at 0 and counts up by one per cycle to PEAK, then down by one per cycle to 0, and repeats. Its period is 2*PEAK cycles and it never leaves 0..PEAK.
- R2: `valley_o` is 1 in exactly those cycles in which the carrier is 0.
- R3: The reference and amplitude are captured only on the clock edge at which the carrier is 0. `pwm_o`, `level_o` and `neg_o` act on the captured sample and ignore input changes during the rest of the period.
- R4: The magnitude is floor(A*M / 2^(RW-1)). Here A is the absolute value of the sample, with the most negative code taken as 2^(RW-1)-1, and M is `amp_in`. A result above PEAK is limited to PEAK.
- R5: `level_o` is 1 exactly when the captured magnitude exceeds HALF = floor(PEAK/2).
- R6: `neg_o` is 1 exactly when the captured sample is negative. A zero sample counts as positive and gives 0.
- R7: The folded reference is 4*min(mag,HALF) - 2*mag, limited to 0..PEAK. `pwm_o` is 1 exactly when the folded reference is greater than the current carrier value.
- R8: While `rst` is high the carrier is 0 and `pwm_o`, `level_o` and `neg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | RW | Signed reference sample |
| amp_in | input | CW | Reference peak, in carrier counts |
| carrier_o | output | CW | Triangular carrier value |
| valley_o | output | 1 | High while the carrier is at 0 |
| pwm_o | output | 1 | Result of comparing the folded reference with the carrier |
| level_o | output | 1 | Upper-band select |
| neg_o | output | 1 | Negative half-cycle flag |

## Verification
The hardest cases sit at the fold boundary. The magnitude must land exactly on HALF or on HALF+1, and the magnitude must be near PEAK, where the fold result goes negative and has to be clamped. These cases are reached only through a particular product of sample and amplitude. The stimulus therefore holds hand-picked pairs for whole periods: half-scale sample at full amplitude, the most negative code, and an oversized amplitude. It mixes these with random samples that change in mid-period, which exercises the hold at the valley.

// File: rtl/folded_ref_pwm.sv
module folded_ref_pwm #(
  parameter int PEAK = 4000,
  parameter int RW   = 16,
  parameter int CW   = $clog2(PEAK + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [RW-1:0] ref_in,
  input  logic        [CW-1:0] amp_in,
  output logic        [CW-1:0] carrier_o,
  output logic                 valley_o,
  output logic                 pwm_o,
  output logic                 level_o,
  output logic                 neg_o
);
  localparam int PW = RW - 1 + CW;
  localparam logic [CW-1:0] PEAK_C = CW'(PEAK);
  localparam logic [CW-1:0] HALF_C = CW'(PEAK / 2);
  localparam logic [RW-2:0] MAXPOS = '1;

  logic [CW-1:0] cnt;
  logic          up;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      cnt <= cnt + 1'b1;
      if (cnt == PEAK_C - 1'b1) up <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) up <= 1'b1;
    end
  end

  logic [RW-1:0] neg_ref;
  logic [RW-2:0] absval;
  logic [PW-1:0] prod;
  logic [CW-1:0] scaled, mag, clampv;
  logic signed [CW+2:0] fold;
  logic [CW-1:0] mref_n;

  assign neg_ref = -ref_in;
  assign absval  = !ref_in[RW-1]        ? ref_in[RW-2:0] :
                   (ref_in[RW-2:0] == '0) ? MAXPOS : neg_ref[RW-2:0];
  assign prod    = PW'(absval) * PW'(amp_in);
  assign scaled  = prod[PW-1:RW-1];
  assign mag     = (scaled > PEAK_C) ? PEAK_C : scaled;
  assign clampv  = (mag > HALF_C) ? HALF_C : mag;
  assign fold    = $signed({1'b0, clampv, 2'b00}) - $signed({2'b00, mag, 1'b0});
  assign mref_n  = fold[CW+2] ? '0 :
                   (fold[CW+1:0] > {2'b00, PEAK_C}) ? PEAK_C : fold[CW-1:0];

  logic [CW-1:0] mref_q;
  logic          lvl_q, neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mref_q <= '0;
      lvl_q  <= 1'b0;
      neg_q  <= 1'b0;
    end else if (cnt == '0) begin
      mref_q <= mref_n;
      lvl_q  <= mag > HALF_C;
      neg_q  <= ref_in[RW-1];
    end
  end

  assign carrier_o = cnt;
  assign valley_o  = (cnt == '0);
  assign pwm_o     = mref_q > cnt;
  assign level_o   = lvl_q;
  assign neg_o     = neg_q;

  assert_carrier_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) ||
             ({1'b0, $past(cnt)} == {1'b0, cnt} + 1'b1));

  assert_carrier_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= PEAK_C);

  assert_valley_exit_R2: assert property (@(posedge clk) disable iff (rst)
    valley_o |=> carrier_o == CW'(1));

  assert_hold_mid_period_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(mref_q) && $stable(lvl_q) && $stable(neg_q));

  assert_fold_range_R7: assert property (@(posedge clk) disable iff (rst)
    mref_q <= PEAK_C);

  assert_upper_band_below_peak_R5: assert property (@(posedge clk) disable iff (rst)
    lvl_q |-> mref_q < PEAK_C);
endmodule

// File: tb/test_folded_ref_pwm.sv
module test_folded_ref_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int PEAK = 100;
  localparam int RW   = 16;
  localparam int CW   = $clog2(PEAK + 1);
  localparam int HALF = PEAK / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [RW-1:0] ref_in = '0;
  logic [CW-1:0] amp_in = '0;
  logic [CW-1:0] carrier_o;
  logic valley_o, pwm_o, level_o, neg_o;

  folded_ref_pwm #(.PEAK(PEAK), .RW(RW), .CW(CW)) i_folded_ref_pwm (
    .clk(clk), .rst(rst), .ref_in(ref_in), .amp_in(amp_in),
    .carrier_o(carrier_o), .valley_o(valley_o), .pwm_o(pwm_o),
    .level_o(level_o), .neg_o(neg_o));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int m_cnt = 0;
  bit m_up = 1;
  int m_mref = 0;
  bit m_lvl = 0;
  bit m_neg = 0;

  function automatic int f_mag(logic signed [RW-1:0] r, int a);
    longint ab;
    longint v;
    ab = r;
    if (ab < 0) ab = -ab;
    if (ab > (longint'(1) << (RW - 1)) - 1) ab = (longint'(1) << (RW - 1)) - 1;
    v = (ab * a) >> (RW - 1);
    if (v > PEAK) v = PEAK;
    return int'(v);
  endfunction

  function automatic int f_mref(int mag);
    int c;
    int f;
    c = (mag > HALF) ? HALF : mag;
    f = 4 * c - 2 * mag;
    if (f < 0) f = 0;
    if (f > PEAK) f = PEAK;
    return f;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    int mag;
    check(carrier_o == CW'(m_cnt), "R1 carrier", int'(carrier_o), m_cnt);
    check(valley_o == (m_cnt == 0), "R2 valley", int'(valley_o), int'(m_cnt == 0));
    check(pwm_o == (m_mref > m_cnt), "R7 pwm (mag R4)", int'(pwm_o), int'(m_mref > m_cnt));
    check(level_o == m_lvl, "R5 level (hold R3)", int'(level_o), int'(m_lvl));
    check(neg_o == m_neg, "R6 polarity (hold R3)", int'(neg_o), int'(m_neg));
    @(posedge clk);
    if (m_cnt == 0) begin
      mag = f_mag(ref_in, int'(amp_in));
      m_lvl = mag > HALF;
      m_neg = ref_in < 0;
      m_mref = f_mref(mag);
    end
    if (m_up) begin
      m_cnt++;
      if (m_cnt == PEAK) m_up = 0;
    end else begin
      m_cnt--;
      if (m_cnt == 0) m_up = 1;
    end
    @(negedge clk);
  endtask

  task automatic hold_case(int r, int a);
    ref_in = RW'(r);
    amp_in = CW'(a);
    for (int i = 0; i < 4 * PEAK; i++) step();
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    // R8: reset state
    check(carrier_o == '0, "R8 carrier", int'(carrier_o), 0);
    check(!pwm_o, "R8 pwm", int'(pwm_o), 0);
    check(!level_o, "R8 level", int'(level_o), 0);
    check(!neg_o, "R8 polarity", int'(neg_o), 0);
    rst = 1'b0;
    hold_case(16384, PEAK);         // R5 magnitude exactly HALF
    hold_case(16712, PEAK);         // R5 magnitude HALF+1
    hold_case(-32768, PEAK);        // R4 most negative code
    hold_case(32767, (1 << CW) - 1); // R4 amplitude above PEAK saturates
    hold_case(0, PEAK);             // R6 zero sample counts as positive
    hold_case(-8000, 60);
    hold_case(24000, 90);
    for (int i = 0; i < 8000; i++) begin
      if ($urandom_range(0, 9) < 3) begin
        ref_in = RW'($urandom);
        amp_in = CW'($urandom_range(0, (1 << CW) - 1));
      end
      step();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule